// File: doc/BRIEF.md
# Inbound Configuration Access Filter

This block sits between the request decoder of a serial packet endpoint and the local configuration register space. Each inbound request arrives with a kind code, a 34-bit address, a byte count, write data and a transaction tag. The block first sorts the request onto one of two guarded paths: an address-window path for plain reads, plain writes and confirmed writes, and a maintenance path for maintenance reads and writes. It then either grants the access, completes it with a denial, or hands it to a separate forwarding output as a request that does not belong to the configuration space.

A granted access drives one cycle of the register port, using the low 20 address bits as the local offset, and is followed by a single response beat. A denied read completes with a zero payload. A denied write reports an error and leaves every register unchanged. Only one configuration request can be in flight: the request input is held not-ready from acceptance until the response or forward beat has gone out.

The control is a four-state machine. `S_IDLE` accepts a request and moves to `S_ACCESS` (grant), `S_RESP` (deny) or `S_FWD` (miss). `S_ACCESS` always moves to `S_RESP`. `S_RESP` and `S_FWD` always return to `S_IDLE`.

Top module: `cfg_access_gate`

## Requirements
- R1: `req_ready` is 1 only in the idle state. After a request is accepted, it stays 0 up to and including the cycle of its response or forward beat, and it returns to 1 in the following cycle.
- R2: A request of kind 0, 1 or 2 hits the window when `req_addr[33:20]` (address bits 0–13 in MSB-first numbering) equals `base_reg[30:17]`. A granted access drives `rf_addr = req_addr[19:0]`.
- R3: Any request whose `req_len` is not 4 bytes is denied.
- R4: When `ext_cfg_block` is 1, every window hit (kinds 0, 1, 2) is denied. Maintenance requests are not affected.
- R5: Kind 1 (plain window write, no response requested) is always denied. It never asserts `rf_en` and reports error status.
- R6: A maintenance request (kind 3 read, kind 4 write) is granted only when `req_addr[19:16] == 0` (the lower 64 KB). Any offset at or above 64 KB is denied.
- R7: A denied request produces one response beat, one cycle after acceptance, with `rsp_data = 0` and no register port activity. Its `rsp_err` is 0 for reads (kinds 0, 3) and 1 for writes (kinds 1, 2, 4).
- R8: A granted request asserts `rf_en` one cycle after acceptance, with `rf_we` set for writes and `rf_wdata = req_wdata`. The response beat follows one cycle later with `rsp_err = 0`, `rsp_tag = req_tag`, `rsp_data` equal to the register's read data for reads, and 0 for writes.
- R9: A window-kind request that misses the window, or any request of kind 5–7, raises `nm_valid` with `nm_tag = req_tag` for one cycle, one cycle after acceptance. It produces no response beat and no register access.
- R10: After reset, `req_ready` = 1 and `rsp_valid`, `rf_en` and `nm_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 3 | 0 win read, 1 win write, 2 win confirmed write, 3 maint read, 4 maint write, 5–7 other |
| req_addr | input | 34 | Request address, bit 33 is MSB-first bit 0 |
| req_len | input | 4 | Transfer length in bytes |
| req_wdata | input | 32 | Write data |
| req_tag | input | 8 | Transaction tag |
| base_reg | input | 32 | Local base-address register, window base in bits 30:17 |
| ext_cfg_block | input | 1 | Blocks all window-path accesses |
| rf_en | output | 1 | Register port access strobe |
| rf_we | output | 1 | Register port write enable |
| rf_addr | output | 20 | Register offset |
| rf_wdata | output | 32 | Register write data |
| rf_rdata | input | 32 | Register read data, valid the cycle after `rf_en` |
| rsp_valid | output | 1 | Response beat |
| rsp_err | output | 1 | 1 = error status, 0 = done |
| rsp_data | output | 32 | Response payload |
| rsp_tag | output | 8 | Echoed tag |
| nm_valid | output | 1 | Request forwarded as not for this block |
| nm_tag | output | 8 | Tag of forwarded request |

## Verification
The decision logic is tried with the same register offsets on both paths, so that a maintenance grant, a window grant and each kind of denial can be told apart by latency, status and payload. Denied writes aim at offsets that alias a location already holding known data in the bench register model, and a later read-back shows whether any write leaked through. Reads are denied by size, by the block bit and by the 64 KB limit while the target holds nonzero data, which separates a zeroed payload from a passed-through one. Misses use a neighbouring base value and an unused kind code, which separates forwarding from denial.

// File: rtl/cfg_gate_pkg.sv
package cfg_gate_pkg;

    localparam logic [2:0] KIND_WIN_RD  = 3'd0;
    localparam logic [2:0] KIND_WIN_WR  = 3'd1;
    localparam logic [2:0] KIND_WIN_WRR = 3'd2;
    localparam logic [2:0] KIND_MNT_RD  = 3'd3;
    localparam logic [2:0] KIND_MNT_WR  = 3'd4;

    typedef enum logic [1:0] {
        ROUTE_GRANT,
        ROUTE_DENY,
        ROUTE_FWD
    } route_e;

    typedef struct packed {
        route_e route;
        logic   is_wr;
    } verdict_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ACCESS,
        S_RESP,
        S_FWD
    } gate_state_e;

endpackage

// File: rtl/cfg_window_match.sv
module cfg_window_match #(
    parameter int ADDR_W   = 34,
    parameter int BASE_W   = 14,
    parameter int BASE_LSB = 17,
    localparam int OFFS_W  = ADDR_W - BASE_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       base_reg,
    output logic              hit,
    output logic [OFFS_W-1:0] offset
);
    logic [BASE_W-1:0] base_field;

    always_comb begin
        base_field = base_reg[BASE_LSB +: BASE_W];
        hit        = (addr[ADDR_W-1 -: BASE_W] == base_field);
        offset     = addr[OFFS_W-1:0];
    end
endmodule

// File: rtl/cfg_req_classify.sv
module cfg_req_classify
    import cfg_gate_pkg::*;
#(
    parameter int OFFS_W     = 20,
    parameter int MNT_OK_W   = 16,
    parameter int LEN_W      = 4,
    parameter int WORD_BYTES = 4
) (
    input  logic [2:0]        kind,
    input  logic [LEN_W-1:0]  len,
    input  logic              win_hit,
    input  logic [OFFS_W-1:0] offset,
    input  logic              ext_block,
    output verdict_t          verdict
);
    logic size_ok;
    logic mnt_in_range;

    always_comb begin
        size_ok      = (len == LEN_W'(WORD_BYTES));
        mnt_in_range = (offset[OFFS_W-1:MNT_OK_W] == '0);
        verdict.is_wr = (kind == KIND_WIN_WR) || (kind == KIND_WIN_WRR) ||
                        (kind == KIND_MNT_WR);
        unique case (kind)
            KIND_WIN_RD, KIND_WIN_WRR: begin
                if (!win_hit)
                    verdict.route = ROUTE_FWD;
                else if (size_ok && !ext_block)
                    verdict.route = ROUTE_GRANT;
                else
                    verdict.route = ROUTE_DENY;
            end
            KIND_WIN_WR:
                verdict.route = win_hit ? ROUTE_DENY : ROUTE_FWD;
            KIND_MNT_RD, KIND_MNT_WR:
                verdict.route = (size_ok && mnt_in_range) ? ROUTE_GRANT : ROUTE_DENY;
            default:
                verdict.route = ROUTE_FWD;
        endcase
    end
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
    import cfg_gate_pkg::*;
#(
    parameter int ADDR_W   = 34,
    parameter int BASE_W   = 14,
    parameter int BASE_LSB = 17,
    parameter int MNT_OK_W = 16,
    parameter int LEN_W    = 4,
    parameter int TAG_W    = 8,
    parameter int DATA_W   = 32,
    localparam int OFFS_W  = ADDR_W - BASE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [31:0]       base_reg,
    input  logic              ext_cfg_block,
    output logic              rf_en,
    output logic              rf_we,
    output logic [OFFS_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              nm_valid,
    output logic [TAG_W-1:0]  nm_tag
);
    gate_state_e       state_q, state_d;
    verdict_t          verdict;
    logic              win_hit;
    logic [OFFS_W-1:0] offset;
    logic              accept;

    logic              grant_q;
    logic              wr_q;
    logic [OFFS_W-1:0] offs_q;
    logic [DATA_W-1:0] wdata_q;
    logic [TAG_W-1:0]  tag_q;

    cfg_window_match #(
        .ADDR_W  (ADDR_W),
        .BASE_W  (BASE_W),
        .BASE_LSB(BASE_LSB)
    ) u_match (
        .addr    (req_addr),
        .base_reg(base_reg),
        .hit     (win_hit),
        .offset  (offset)
    );

    cfg_req_classify #(
        .OFFS_W  (OFFS_W),
        .MNT_OK_W(MNT_OK_W),
        .LEN_W   (LEN_W)
    ) u_classify (
        .kind     (req_kind),
        .len      (req_len),
        .win_hit  (win_hit),
        .offset   (offset),
        .ext_block(ext_cfg_block),
        .verdict  (verdict)
    );

    assign accept = req_valid && (state_q == S_IDLE);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_valid) begin
                    unique case (verdict.route)
                        ROUTE_GRANT: state_d = S_ACCESS;
                        ROUTE_DENY:  state_d = S_RESP;
                        default:     state_d = S_FWD;
                    endcase
                end
            end
            S_ACCESS: state_d = S_RESP;
            S_RESP:   state_d = S_IDLE;
            S_FWD:    state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // Request capture at acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= 1'b0;
            wr_q    <= 1'b0;
            offs_q  <= '0;
            wdata_q <= '0;
            tag_q   <= '0;
        end else if (accept) begin
            grant_q <= (verdict.route == ROUTE_GRANT);
            wr_q    <= verdict.is_wr;
            offs_q  <= offset;
            wdata_q <= req_wdata;
            tag_q   <= req_tag;
        end
    end

    // Outputs from state
    always_comb begin
        req_ready = 1'b0;
        rf_en     = 1'b0;
        rf_we     = 1'b0;
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_data  = '0;
        nm_valid  = 1'b0;
        unique case (state_q)
            S_IDLE:   req_ready = 1'b1;
            S_ACCESS: begin
                rf_en = 1'b1;
                rf_we = wr_q;
            end
            S_RESP: begin
                rsp_valid = 1'b1;
                rsp_err   = !grant_q && wr_q;
                if (grant_q && !wr_q)
                    rsp_data = rf_rdata;
            end
            S_FWD:    nm_valid = 1'b1;
            default:  req_ready = 1'b0;
        endcase
        rf_addr  = offs_q;
        rf_wdata = wdata_q;
        rsp_tag  = tag_q;
        nm_tag   = tag_q;
    end
endmodule

// File: rtl/cfg_access_gate_chk.sv
module cfg_access_gate_chk #(
    parameter int LEN_W  = 4,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_kind,
    input logic [LEN_W-1:0]  req_len,
    input logic              ext_cfg_block,
    input logic              rf_en,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [DATA_W-1:0] rsp_data,
    input logic              nm_valid
);
    logic acc;
    assign acc = req_valid && req_ready;

    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !req_ready); // R1
    AST_PORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |-> !req_ready); // R1
    AST_SIZE_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_len != LEN_W'(4)) |=> !rf_en); // R3
    AST_EXT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        acc && ext_cfg_block && (req_kind <= 3'd2) |=> !rf_en); // R4
    AST_PLAIN_WR_DENY: assert property (@(posedge clk) disable iff (!rst_n)
        acc && (req_kind == 3'd1) |=> !rf_en); // R5
    AST_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_err |-> (rsp_data == '0)); // R7
    AST_ACCESS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rf_en |=> rsp_valid && !rsp_err); // R8
    AST_FWD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        nm_valid |-> !rf_en && !rsp_valid); // R9
endmodule

bind cfg_access_gate cfg_access_gate_chk #(
    .LEN_W (LEN_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_kind     (req_kind),
    .req_len      (req_len),
    .ext_cfg_block(ext_cfg_block),
    .rf_en        (rf_en),
    .rsp_valid    (rsp_valid),
    .rsp_err      (rsp_err),
    .rsp_data     (rsp_data),
    .nm_valid     (nm_valid)
);

// File: tb/sim_cfg_access_gate.sv
module sim_cfg_access_gate;
    localparam int CLK_PERIOD = 10;
    localparam logic [13:0] BASE = 14'h2A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_kind = '0;
    logic [33:0] req_addr = '0;
    logic [3:0]  req_len = 4'd4;
    logic [31:0] req_wdata = '0;
    logic [7:0]  req_tag = '0;
    logic [31:0] base_reg;
    logic        ext_cfg_block = 1'b0;
    logic        rf_en, rf_we;
    logic [19:0] rf_addr;
    logic [31:0] rf_wdata;
    logic [31:0] rf_rdata = '0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_data;
    logic [7:0]  rsp_tag;
    logic        nm_valid;
    logic [7:0]  nm_tag;

    int checks = 0;
    int errors = 0;
    int rf_cycles = 0;
    logic [19:0] last_addr = '0;
    logic [31:0] mem [16];

    assign base_reg = {1'b0, BASE, 17'h0};

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_access_gate u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len),
        .req_wdata(req_wdata), .req_tag(req_tag), .base_reg(base_reg),
        .ext_cfg_block(ext_cfg_block), .rf_en(rf_en), .rf_we(rf_we),
        .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .nm_valid(nm_valid), .nm_tag(nm_tag)
    );

    // Register file model: synchronous read, index from offset bits 5:2
    always @(posedge clk) begin
        if (rf_en) begin
            rf_cycles <= rf_cycles + 1;
            last_addr <= rf_addr;
            if (rf_we) mem[rf_addr[5:2]] <= rf_wdata;
            rf_rdata <= mem[rf_addr[5:2]];
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Issue one request; report beat type (1 rsp, 2 fwd, 0 none) and latency
    task automatic issue(input logic [2:0] kind, input logic [33:0] addr,
                         input logic [3:0] len, input logic [31:0] wd,
                         input logic [7:0] tag, output int beat, output int lat,
                         output logic err, output logic [31:0] data,
                         output logic [7:0] otag, output int rf_used);
        int rf0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_addr = addr;
        req_len = len; req_wdata = wd; req_tag = tag;
        rf0 = rf_cycles;
        @(negedge clk);
        req_valid = 1'b0;
        beat = 0; lat = 0; err = 1'b0; data = '0; otag = '0;
        for (int i = 1; i <= 5; i++) begin
            chk(!req_ready, "R1 ready low while busy", 32'(req_ready), 0);
            if (rsp_valid || nm_valid) begin
                beat = rsp_valid ? 1 : 2;
                lat = i; err = rsp_err; data = rsp_data;
                otag = rsp_valid ? rsp_tag : nm_tag;
                break;
            end
            @(negedge clk);
        end
        @(negedge clk);
        chk(req_ready, "R1 ready back after beat", 32'(req_ready), 1);
        rf_used = rf_cycles - rf0;
    endtask

    // Expect a response beat
    task automatic expect_rsp(input string req, input logic [2:0] kind,
                              input logic [33:0] addr, input logic [3:0] len,
                              input logic [31:0] wd, input int exp_lat,
                              input logic exp_err, input logic [31:0] exp_data);
        int beat, lat, rfu;
        logic err;
        logic [31:0] data;
        logic [7:0] otag;
        logic [7:0] tag;
        tag = 8'(checks + 8'h31);
        issue(kind, addr, len, wd, tag, beat, lat, err, data, otag, rfu);
        chk(beat == 1, {req, " response beat"}, 32'(beat), 1);
        chk(lat == exp_lat, {req, " latency"}, 32'(lat), 32'(exp_lat));
        chk(err == exp_err, {req, " status"}, 32'(err), 32'(exp_err));
        chk(data == exp_data, {req, " payload"}, data, exp_data);
        chk(otag == tag, {req, " tag echo"}, 32'(otag), 32'(tag));
        chk(rfu == (exp_lat == 2 ? 1 : 0), {req, " register port cycles"},
            32'(rfu), (exp_lat == 2) ? 1 : 0);
    endtask

    function automatic logic [33:0] win(input logic [19:0] off);
        return {BASE, off};
    endfunction

    task automatic t_reset;
        chk(req_ready == 1'b1, "R10 reset ready", 32'(req_ready), 1);
        chk(!rsp_valid && !rf_en && !nm_valid, "R10 reset outputs idle",
            32'({rsp_valid, rf_en, nm_valid}), 0);
    endtask

    task automatic t_maint_grant;
        expect_rsp("R8 R6 maint write low 64K", 3'd4, {14'h0, 20'h00040}, 4'd4,
                   32'hA5A5_0001, 2, 1'b0, 32'h0);
        expect_rsp("R8 maint read back", 3'd3, {14'h0, 20'h00040}, 4'd4, 0, 2, 1'b0,
                   32'hA5A5_0001);
    endtask

    task automatic t_window_grant;
        expect_rsp("R8 window confirmed write", 3'd2, win(20'h00044), 4'd4,
                   32'h1234_5678, 2, 1'b0, 32'h0);
        chk(last_addr == 20'h00044, "R2 offset passed to rf_addr", 32'(last_addr),
            32'h44);
        expect_rsp("R2 window read", 3'd0, win(20'h00044), 4'd4, 0, 2, 1'b0,
                   32'h1234_5678);
        expect_rsp("R2 window read high offset", 3'd0, win(20'hFFF80), 4'd4, 0, 2,
                   1'b0, 32'hA5A5_0001);
        chk(last_addr == 20'hFFF80, "R2 high offset passed", 32'(last_addr),
            32'hFFF80);
    endtask

    task automatic t_plain_write;
        expect_rsp("R5 plain window write denied", 3'd1, win(20'h00044), 4'd4,
                   32'hFFFF_FFFF, 1, 1'b1, 32'h0);
        expect_rsp("R5 location untouched", 3'd3, {14'h0, 20'h00044}, 4'd4, 0, 2,
                   1'b0, 32'h1234_5678);
    endtask

    task automatic t_maint_range;
        expect_rsp("R6 R7 maint read at 64K denied", 3'd3, {14'h0, 20'h10044}, 4'd4,
                   0, 1, 1'b0, 32'h0);
        expect_rsp("R6 R7 maint write above 64K denied", 3'd4, {14'h0, 20'h20044},
                   4'd4, 32'hDEAD_0000, 1, 1'b1, 32'h0);
        expect_rsp("R6 maint write edge 0xFFFC granted", 3'd4, {14'h0, 20'h0FFFC},
                   4'd4, 32'h0000_BEEF, 2, 1'b0, 32'h0);
        expect_rsp("R7 aliased location untouched", 3'd3, {14'h0, 20'h00044}, 4'd4,
                   0, 2, 1'b0, 32'h1234_5678);
    endtask

    task automatic t_size;
        expect_rsp("R3 two-byte read denied", 3'd0, win(20'h00044), 4'd2, 0, 1, 1'b0,
                   32'h0);
        expect_rsp("R3 eight-byte maint write denied", 3'd4, {14'h0, 20'h00044},
                   4'd8, 32'h5555_5555, 1, 1'b1, 32'h0);
        expect_rsp("R3 location untouched", 3'd0, win(20'h00044), 4'd4, 0, 2, 1'b0,
                   32'h1234_5678);
    endtask

    task automatic t_ext_block;
        ext_cfg_block = 1'b1;
        expect_rsp("R4 blocked window read", 3'd0, win(20'h00044), 4'd4, 0, 1, 1'b0,
                   32'h0);
        expect_rsp("R4 blocked confirmed write", 3'd2, win(20'h00044), 4'd4,
                   32'h7777_7777, 1, 1'b1, 32'h0);
        expect_rsp("R4 maint path still open", 3'd3, {14'h0, 20'h00044}, 4'd4, 0, 2,
                   1'b0, 32'h1234_5678);
        ext_cfg_block = 1'b0;
    endtask

    task automatic t_forward;
        int beat, lat, rfu;
        logic err;
        logic [31:0] data;
        logic [7:0] otag;
        issue(3'd0, {BASE + 14'd1, 20'h00044}, 4'd4, 0, 8'hC3, beat, lat, err, data,
              otag, rfu);
        chk(beat == 2, "R9 window miss forwarded", 32'(beat), 2);
        chk(lat == 1, "R9 forward latency", 32'(lat), 1);
        chk(otag == 8'hC3, "R9 forward tag", 32'(otag), 32'hC3);
        chk(rfu == 0, "R9 no register access", 32'(rfu), 0);
        issue(3'd6, win(20'h00044), 4'd4, 0, 8'h5A, beat, lat, err, data, otag, rfu);
        chk(beat == 2 && otag == 8'h5A, "R9 unknown kind forwarded", 32'(beat), 2);
        chk(rfu == 0, "R9 unknown kind no access", 32'(rfu), 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 32'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_maint_grant();
        t_window_grant();
        t_plain_write();
        t_maint_range();
        t_size();
        t_ext_block();
        t_forward();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule